// File: doc/BRIEF.md
# Oscillator-Cycle Watchdog with Top-Address Restart

This block is a watchdog that guards a processor against runaway code. It counts clock cycles through a system prescaler that other logic may share, followed by a dedicated watchdog counter. The prescaler and the watchdog counter together form one composite count. When that count reaches the selected limit, the block drives a reset pulse of fixed length. The reset pulse is an internal reset, so it clears both counters, and the next timeout period starts when the pulse ends.

Software restarts the timeout by writing to the highest address of the bus. The written data does not matter. That address also holds the low byte of the reset vector, so a read there returns the vector byte and no watchdog state. A restart write zeroes the watchdog counter and the upper prescaler stages. The lowest prescaler stages keep counting, so the actual time to expiry after a restart can be shorter than the nominal period by up to one low-stage cycle.

A reset-vector fetch clears the whole prescaler and leaves the watchdog counter alone. One static input disables the reset. A second static input selects the short period instead of the long one.

Top module: `cop_watchdog`

## Requirements
- R1: While `por_n` is low and after it is released, `cop_rst` is low. `bus_rdata` is 0 whenever a read of the top address is not in progress.
- R2: With `short_sel` = 0, the composite count starts at 0 when `por_n` is released and advances by one on each clock edge. `cop_rst` goes high on clock edge 2^LONG_LOG − 2^GUARD_LOG + 1 after the release.
- R3: With `short_sel` = 1, `cop_rst` goes high on clock edge 2^SHORT_LOG − 2^GUARD_LOG + 1 after the release.
- R4: `cop_rst` stays high for exactly RST_LEN cycles. Both counters are held at 0 during that time. The next rise comes exactly one full period plus one cycle after the fall.
- R5: A write strobe (`bus_wr` = 1) to the address whose bits are all ones restarts the timeout. On that clock edge the watchdog counter and prescaler stages CLR_LO and above become 0, and the low CLR_LO stages increment modulo 2^CLR_LO. A restart in the cycle just before expiry prevents the reset.
- R6: A write to any other address has no effect on the timeout.
- R7: A read strobe (`bus_rd` = 1) to the all-ones address returns `vec_lo` on `bus_rdata` in the same cycle.
- R8: A pulse on `vec_fetch` zeroes every prescaler stage on that edge and keeps the watchdog counter. The next expiry is then computed from the reduced composite count.
- R9: While `cop_disable` = 1, `cop_rst` never rises, however long the block runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, vector byte at the top address, else 0 |
| vec_lo | input | DATA_W | Low byte of the reset vector |
| vec_fetch | input | 1 | Reset-vector fetch indication, clears the prescaler |
| cop_disable | input | 1 | Static option: suppress watchdog reset |
| short_sel | input | 1 | Static option: select the short timeout |
| cop_rst | output | 1 | Watchdog reset pulse |

## Verification
The bench builds the block with PRE_W = 8, CLR_LO = 3, LONG_LOG = 12, SHORT_LOG = 8, GUARD_LOG = 2 and RST_LEN = 8. These values keep the same structure as the defaults: a long period of 4092 cycles and a short period of 252 cycles. Both periods, several back-to-back expiries, a restart one cycle before expiry and a long disabled run therefore fit in a short run. With these widths the watchdog counter wraps and the low-stage phase after a restart changes from case to case. The fetch-versus-restart interplay can then be checked against an exact expiry cycle, not against a range.

// File: rtl/cop_pkg.sv
package cop_pkg;

  // Clear requests applied to the counter chain in one cycle.
  typedef struct packed {
    logic hard;   // internal reset: both counters to zero
    logic full;   // vector fetch: whole prescaler to zero
    logic part;   // restart write: upper stages and watchdog counter
  } clr_req_t;

  // Nominal period: 2^log_len - 2^guard_log cycles.
  function automatic logic [31:0] timeout_cycles(input int unsigned log_len,
                                                 input int unsigned guard_log);
    return (32'd1 << log_len) - (32'd1 << guard_log);
  endfunction

  // Low stages after a restart write: increment, wrapping in their own width.
  function automatic logic [31:0] low_after_restart(input logic [31:0] low_now,
                                                    input int unsigned lo_bits);
    return (low_now + 32'd1) & ((32'd1 << lo_bits) - 32'd1);
  endfunction

endpackage

// File: rtl/cop_prescaler.sv
module cop_prescaler #(
  parameter int unsigned PRE_W  = 13,
  parameter int unsigned CLR_LO = 5
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  cop_pkg::clr_req_t    clr,
  output logic [PRE_W-1:0]     pre_q,
  output logic                 carry
);
  localparam int unsigned HI_W = PRE_W - CLR_LO;

  logic [PRE_W-1:0] pre_d;
  logic             any_clr;

  assign any_clr = clr.hard | clr.full | clr.part;

  generate
    if (CLR_LO > 0) begin : g_split
      logic [CLR_LO-1:0] lo_inc;
      logic [31:0]       lo_wide;
      assign lo_wide = cop_pkg::low_after_restart(32'(pre_q[CLR_LO-1:0]), CLR_LO);
      assign lo_inc  = lo_wide[CLR_LO-1:0];
      always_comb begin
        if (clr.hard || clr.full) begin
          pre_d = '0;
        end else if (clr.part) begin
          pre_d = {{HI_W{1'b0}}, lo_inc};
        end else begin
          pre_d = pre_q + PRE_W'(1);
        end
      end
    end else begin : g_whole
      always_comb begin
        if (any_clr) begin
          pre_d = '0;
        end else begin
          pre_d = pre_q + PRE_W'(1);
        end
      end
    end
  endgenerate

  // A carry leaves the top stage only on a natural wrap.
  assign carry = !any_clr && (&pre_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/cop_counter.sv
module cop_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cop_pulse.sv
module cop_pulse #(
  parameter int unsigned RST_LEN = 32
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned LEN_W = $clog2(RST_LEN + 1);

  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] left_d;

  always_comb begin
    if (left_q != '0) begin
      left_d = left_q - LEN_W'(1);
    end else if (fire) begin
      left_d = LEN_W'(RST_LEN);
    end else begin
      left_d = '0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      left_q <= '0;
    end else begin
      left_q <= left_d;
    end
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/cop_bus_decode.sv
module cop_bus_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] vec_lo,
  output logic              kick,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic at_top;

  assign at_top    = (bus_addr == TOP_ADDR);
  assign kick      = bus_wr && at_top;
  assign bus_rdata = (bus_rd && at_top) ? vec_lo : '0;
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PRE_W     = 13,
  parameter int unsigned CLR_LO    = 5,
  parameter int unsigned LONG_LOG  = 18,
  parameter int unsigned SHORT_LOG = 13,
  parameter int unsigned GUARD_LOG = 4,
  parameter int unsigned RST_LEN   = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] vec_lo,
  input  logic              vec_fetch,
  input  logic              cop_disable,
  input  logic              short_sel,
  output logic              cop_rst
);
  localparam int unsigned COP_W = LONG_LOG - PRE_W;
  localparam int unsigned V_W   = LONG_LOG;
  localparam logic [V_W-1:0] LIM_LONG  = V_W'(cop_pkg::timeout_cycles(LONG_LOG, GUARD_LOG));
  localparam logic [V_W-1:0] LIM_SHORT = V_W'(cop_pkg::timeout_cycles(SHORT_LOG, GUARD_LOG));

  // Named internal events, visible to the bound checker.
  logic              kick;
  logic              hit;
  logic              rst_active;
  logic              carry;
  logic [PRE_W-1:0]  pre_q;
  logic [COP_W-1:0]  cop_q;
  logic [V_W-1:0]    comp;
  logic [V_W-1:0]    limit;
  cop_pkg::clr_req_t clr;

  cop_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .vec_lo    (vec_lo),
    .kick      (kick),
    .bus_rdata (bus_rdata)
  );

  assign comp  = {cop_q, pre_q};
  assign limit = short_sel ? LIM_SHORT : LIM_LONG;
  assign hit   = (comp == limit) && !cop_disable && !rst_active && !kick;

  assign clr.hard = hit || rst_active;
  assign clr.full = vec_fetch;
  assign clr.part = kick;

  cop_prescaler #(.PRE_W(PRE_W), .CLR_LO(CLR_LO)) u_pre (
    .clk   (clk),
    .por_n (por_n),
    .clr   (clr),
    .pre_q (pre_q),
    .carry (carry)
  );

  cop_counter #(.CNT_W(COP_W)) u_cop (
    .clk   (clk),
    .por_n (por_n),
    .clr   (clr.hard || clr.part),
    .inc   (carry),
    .cnt_q (cop_q)
  );

  cop_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk    (clk),
    .por_n  (por_n),
    .fire   (hit),
    .active (rst_active)
  );

  assign cop_rst = rst_active;
endmodule

// File: rtl/cop_watchdog_sva.sv
module cop_watchdog_sva #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PRE_W   = 13,
  parameter int unsigned CLR_LO  = 5,
  parameter int unsigned COP_W   = 5,
  parameter int unsigned RST_LEN = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] vec_lo,
  input logic              vec_fetch,
  input logic              cop_disable,
  input logic              cop_rst,
  input logic              kick,
  input logic              hit,
  input logic              rst_active,
  input logic [PRE_W-1:0]  pre_q,
  input logic [COP_W-1:0]  cop_q
);
  localparam int unsigned HI_W = $clog2(RST_LEN + 2);

  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hi_cnt <= '0;
    end else if (cop_rst) begin
      hi_cnt <= hi_cnt + HI_W'(1);
    end else begin
      hi_cnt <= '0;
    end
  end

  p_expiry_fires_r2: assert property (@(posedge clk) disable iff (!por_n)
    hit |=> cop_rst);

  p_pulse_len_r4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(cop_rst) |-> (hi_cnt == HI_W'(RST_LEN)));

  p_held_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
    rst_active |=> (cop_q == '0) && (pre_q == '0));

  p_restart_clears_r5: assert property (@(posedge clk) disable iff (!por_n)
    (kick && !rst_active) |=> (cop_q == '0) && (pre_q[PRE_W-1:CLR_LO] == '0));

  p_fetch_keeps_cop_r8: assert property (@(posedge clk) disable iff (!por_n)
    (vec_fetch && !kick && !rst_active && !hit) |=>
      (pre_q == '0) && (cop_q == $past(cop_q)));

  p_vector_read_r7: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && (bus_addr == {ADDR_W{1'b1}})) |-> (bus_rdata == vec_lo));

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!por_n)
    (cop_disable && !cop_rst) |=> !cop_rst);
endmodule

bind cop_watchdog cop_watchdog_sva #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .PRE_W   (PRE_W),
  .CLR_LO  (CLR_LO),
  .COP_W   (COP_W),
  .RST_LEN (RST_LEN)
) u_sva (
  .clk         (clk),
  .por_n       (por_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .vec_lo      (vec_lo),
  .vec_fetch   (vec_fetch),
  .cop_disable (cop_disable),
  .cop_rst     (cop_rst),
  .kick        (kick),
  .hit         (hit),
  .rst_active  (rst_active),
  .pre_q       (pre_q),
  .cop_q       (cop_q)
);

// File: tb/cop_watchdog_tb.sv
module cop_watchdog_tb;
  localparam int ADDR_W = 16, DATA_W = 8;
  localparam int PRE_W = 8, CLR_LO = 3, LONG_LOG = 12, SHORT_LOG = 8;
  localparam int GUARD_LOG = 2, RST_LEN = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, vec_fetch = 1'b0;
  logic cop_disable = 1'b0, short_sel = 1'b0;
  logic [DATA_W-1:0] vec_lo = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic cop_rst;

  int checks = 0, errors = 0;
  int m_v = 0, m_rc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cop_watchdog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .CLR_LO(CLR_LO),
    .LONG_LOG(LONG_LOG), .SHORT_LOG(SHORT_LOG), .GUARD_LOG(GUARD_LOG),
    .RST_LEN(RST_LEN)) u_dut (
    .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .vec_lo(vec_lo), .vec_fetch(vec_fetch),
    .cop_disable(cop_disable), .short_sel(short_sel), .cop_rst(cop_rst));

  // Period from the requirement text, stated independently of the RTL.
  function automatic int period(input bit sh);
    if (sh) return (2 ** SHORT_LOG) - (2 ** GUARD_LOG);
    return (2 ** LONG_LOG) - (2 ** GUARD_LOG);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Requirement-level cycle model of the composite count and the pulse.
  task automatic model_edge();
    bit k;
    k = bus_wr && (bus_addr == 16'hFFFF);
    if (m_rc != 0) begin
      m_v = 0; m_rc--;
    end else if (m_v == period(short_sel) && !cop_disable && !k) begin
      m_v = 0; m_rc = RST_LEN;
    end else if (k && vec_fetch) begin
      m_v = 0;
    end else if (k) begin
      m_v = (m_v + 1) % (2 ** CLR_LO);
    end else if (vec_fetch) begin
      m_v = m_v - (m_v % (2 ** PRE_W));
    end else begin
      m_v = (m_v + 1) % (2 ** LONG_LOG);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cop_rst == (m_rc != 0), "R2 R4 R5 R8 model", int'(cop_rst), int'(m_rc != 0));
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; vec_fetch = 0; bus_addr = '0;
  endtask

  task automatic do_por(input bit sh, input bit dis);
    @(negedge clk);
    por_n = 0; idle(); short_sel = sh; cop_disable = dis;
    repeat (3) @(negedge clk);
    m_v = 0; m_rc = 0;
    por_n = 1;
  endtask

  // Steps until cop_rst is seen high; returns the step count (capped).
  task automatic steps_to_rise(input int cap, output int n);
    n = 0;
    do begin
      step(); n++;
    end while (!cop_rst && n < cap);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, tl, ts, lo;
    void'($urandom(32'd2024));
    tl = period(0); ts = period(1);

    // R1: reset state
    repeat (2) @(negedge clk);
    check(cop_rst == 0, "R1 in reset", int'(cop_rst), 0);
    check(bus_rdata == 0, "R1 rdata idle", int'(bus_rdata), 0);
    do_por(0, 0);
    #1 check(cop_rst == 0, "R1 after release", int'(cop_rst), 0);

    // R2: long period exact edge
    steps_to_rise(tl + 10, n);
    check(n == tl + 1, "R2 long expiry edge", n, tl + 1);

    // R4: pulse width and repeat
    n = 1;
    while (cop_rst && n < 100) begin step(); if (cop_rst) n++; end
    check(n == RST_LEN, "R4 pulse length", n, RST_LEN);
    steps_to_rise(tl + 10, n);
    check(n == tl + 1, "R4 restart from zero", n, tl + 1);

    // R3: short period exact edge
    do_por(1, 0);
    steps_to_rise(ts + 10, n);
    check(n == ts + 1, "R3 short expiry edge", n, ts + 1);

    // R5: restart one cycle before expiry
    do_por(1, 0);
    repeat (ts - 1) step();
    bus_wr = 1; bus_addr = 16'hFFFF;
    step();
    idle();
    check(cop_rst == 0, "R5 restart prevents reset", int'(cop_rst), 0);
    lo = ts % (2 ** CLR_LO);
    steps_to_rise(ts + 10, n);
    check(n == ts - lo + 1, "R5 expiry after restart", n, ts - lo + 1);

    // R6: write elsewhere is ignored
    do_por(1, 0);
    repeat (ts - 1) step();
    bus_wr = 1; bus_addr = 16'hFFFE;
    step();
    idle();
    steps_to_rise(10, n);
    check(n == 1, "R6 other address ignored", n, 1);

    // R8: vector fetch clears prescaler, keeps watchdog counter
    do_por(0, 0);
    repeat (600) step();
    vec_fetch = 1;
    step();
    idle();
    lo = 600 - (600 % (2 ** PRE_W));
    steps_to_rise(tl + 10, n);
    check(n == tl - lo + 1, "R8 expiry after fetch", n, tl - lo + 1);

    // R7: vector read
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      vec_lo = DATA_W'($urandom);
      bus_rd = 1; bus_addr = 16'hFFFF;
      #1 check(bus_rdata == vec_lo, "R7 vector byte", int'(bus_rdata), int'(vec_lo));
      bus_addr = 16'h8000 | ADDR_W'($urandom_range(0, 16'h7FFF));
      #1 check(bus_rdata == 0, "R7 R1 other address reads 0", int'(bus_rdata), 0);
      bus_rd = 0; bus_addr = 16'hFFFF;
      #1 check(bus_rdata == 0, "R1 no strobe reads 0", int'(bus_rdata), 0);
    end
    idle();

    // R9: disabled, run past two long periods
    do_por(0, 1);
    n = 0;
    for (int i = 0; i < 2 * tl + 50; i++) begin
      step(); if (cop_rst) n++;
    end
    check(n == 0, "R9 disabled never resets", n, 0);

    // Random mix against the model
    for (int b = 0; b < 4; b++) begin
      do_por(b[0], 0);
      for (int i = 0; i < 3000; i++) begin
        bus_wr    = ($urandom_range(0, 199) == 0);
        vec_fetch = ($urandom_range(0, 499) == 0);
        bus_rd    = ($urandom_range(0, 3) == 0);
        vec_lo    = DATA_W'($urandom);
        bus_addr  = ($urandom_range(0, 1) == 0) ? 16'hFFFF : ADDR_W'($urandom_range(0, 16'hFFFE));
        if (bus_wr && $urandom_range(0, 2) == 0) bus_addr = 16'hFFFE;
        #1 check(bus_rdata == ((bus_rd && bus_addr == 16'hFFFF) ? vec_lo : 8'h00),
                 "R7 random read", int'(bus_rdata),
                 int'((bus_rd && bus_addr == 16'hFFFF) ? vec_lo : 8'h00));
        step();
      end
      idle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule